// File: doc/BRIEF.md
# EEPROM Program and Erase Sequencer

This block drives writes into a small on-chip EEPROM array that is modelled as registers inside it. Software never stores a byte directly. It first sets a latch mode in a control register, and its next array write captures one target address and one data byte. It then raises a programming-voltage enable and holds it for a minimum number of clock cycles. When the enable drops, the captured operation is committed. The operation can be a bit-clearing program, a byte erase, an aligned row erase or a bulk erase.

A hidden configuration byte sits one position past the last array byte. It can only be reached through its own access space. At every warm reset its value is copied into a live configuration register, and bit 0 of that register decides whether array accesses are honoured until the next reset. All misuse is reported through sticky error flags in a status register, which are cleared by writing ones. The request port accepts one access per cycle, and read data returns one cycle after the read is accepted.

Top module: `eeprom_seq_ctrl`

## Requirements
- R1: The control register holds bit0=PGM (voltage enable), bit1=LAT (latch mode), bit2=ERA (erase), bit3=ROW and bit4=BYT, and reads back in space 1 with bits 7:5 at zero. A control write with bit1 clear loads zero into the whole register, so PGM is never set without LAT.
- R2: A control write that raises LAT and PGM together from both clear is rejected. The register keeps its old value and status bit0 is set.
- R3: A control write that sets PGM while no address/data pair is latched sets status bit1.
- R4: With LAT set and the array enabled, a write to the array (space 0, address below the array size) or to the configuration byte (space 3) leaves storage unchanged, latches the address and data, and sets status bit5 (latch valid). A further such write while a pair is already latched, or any such write with LAT clear, sets status bit3 and changes nothing.
- R5: The pulse length is the number of clock edges from the one that accepts the PGM-setting write to the one that accepts the PGM-clearing write. A pulse shorter than MIN_PULSE sets status bit2, but the operation is still committed.
- R6: When PGM is cleared with ERA clear, the target byte becomes its old value AND the latched data.
- R7: When PGM is cleared with ERA and BYT set, only the target byte becomes 0xFF. BYT takes priority over ROW.
- R8: With ERA and ROW set and BYT clear, every array byte whose address equals the target address with its low four bits ignored becomes 0xFF. The array bytes outside that row are unchanged.
- R9: With ERA set and both ROW and BYT clear, every array byte and the configuration byte become 0xFF.
- R10: When the latched target is the configuration byte, any erase mode acts on that byte alone.
- R11: A read of the array while LAT is set sets status bit4.
- R12: A warm reset clears the control register, the latch and the status, and loads the live configuration (read in space 3) from the stored configuration byte. While live bit0 is 0, array reads return 0x00 and array writes are ignored without an error flag.
- R13: Status bits 4:0 stay set until a status write (space 2) with a 1 in that bit position. The latch-valid bit clears when a latched operation commits.
- R14: The request ready output is always high. A read's data and its response-valid pulse appear one cycle after the read is accepted, and writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous warm reset, active low |
| por_n | input | 1 | Synchronous power-on fill of the array with 0xFF, active low |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | 0 array, 1 control, 2 status, 3 configuration |
| req_addr | input | AW | Array byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |

## Verification
The bench aims at the edges of the pulse window. A pulse of exactly the minimum length must commit cleanly, and one that is a single edge shorter must set the short flag. An off-by-one counter fails one side or the other. Row erase is checked on the bytes just outside the row, and a BYT-plus-ROW erase is checked on the byte next to its target. A design that got the alignment or the mode priority wrong would wipe bytes that should survive. Configuration-byte erases are checked with bulk mode selected, and the configuration byte is checked after a real bulk erase. A design that mishandled either case would erase the whole array or leave a stale configuration value after reset.

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl #(
  parameter int ARRAY_BYTES = 512,
  parameter int ROW_BYTES   = 16,
  parameter int MIN_PULSE   = 10000,
  localparam int DEPTH = ARRAY_BYTES + 1,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(MIN_PULSE + 1),
  localparam int RB    = $clog2(ROW_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_space,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  output logic          rsp_valid,
  output logic [7:0]    rsp_rdata
);
  localparam logic [1:0] SP_ARR = 2'd0, SP_CTL = 2'd1, SP_ST = 2'd2, SP_CFG = 2'd3;
  localparam logic [AW-1:0] CFG_IDX = AW'(ARRAY_BYTES);

  logic [7:0]    mem [DEPTH];
  logic [4:0]    ctl;
  logic [4:0]    err;
  logic          lat_v;
  logic [AW-1:0] lat_a;
  logic [7:0]    lat_d;
  logic [CW-1:0] cnt;
  logic [7:0]    cfg_live;
  logic [7:0]    rdata;

  assign req_ready = 1'b1;

  wire wr     = req_valid & req_write;
  wire rd     = req_valid & ~req_write;
  wire arr_en = cfg_live[0];
  wire in_arr = req_addr < CFG_IDX;

  wire       ctl_wr  = wr && req_space == SP_CTL;
  wire [1:0] rise    = ~ctl[1:0] & req_wdata[1:0];
  wire       reject  = ctl_wr && rise == 2'b11;
  wire [4:0] ctl_nx  = req_wdata[1] ? req_wdata[4:0] : 5'd0;
  wire       pgm_on  = ctl_wr && !reject && ctl_nx[0];
  wire       pgm_off = ctl_wr && !reject && !ctl_nx[0] && ctl[0];
  wire       commit  = pgm_off && lat_v;
  wire       short_p = pgm_off && cnt < CW'(MIN_PULSE);

  wire          arr_wr   = wr && ((req_space == SP_ARR && arr_en && in_arr) || req_space == SP_CFG);
  wire [AW-1:0] wr_idx   = (req_space == SP_CFG) ? CFG_IDX : req_addr;
  wire          latch_ok = arr_wr && ctl[1] && !lat_v;
  wire          wr_err   = arr_wr && !latch_ok;
  wire          rd_err   = rd && req_space == SP_ARR && arr_en && in_arr && ctl[1];
  wire          nolat    = pgm_on && (!ctl[1] || !lat_v);
  wire [4:0]    st_clr   = (wr && req_space == SP_ST) ? req_wdata[4:0] : 5'd0;

  always_comb begin
    case (req_space)
      SP_ARR:  rdata = (arr_en && in_arr) ? mem[req_addr] : 8'h00;
      SP_CTL:  rdata = {3'b000, ctl};
      SP_ST:   rdata = {2'b00, lat_v, err};
      default: rdata = cfg_live;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!ctl[2]) begin
          if (AW'(i) == lat_a) mem[i] <= mem[i] & lat_d;
        end else if (ctl[4] || lat_a == CFG_IDX) begin
          if (AW'(i) == lat_a) mem[i] <= 8'hFF;
        end else if (ctl[3]) begin
          if (i < ARRAY_BYTES && (AW'(i) >> RB) == (lat_a >> RB)) mem[i] <= 8'hFF;
        end else begin
          mem[i] <= 8'hFF;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl       <= '0;
      err       <= '0;
      lat_v     <= 1'b0;
      lat_a     <= '0;
      lat_d     <= '0;
      cnt       <= '0;
      cfg_live  <= mem[CFG_IDX];
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (ctl_wr && !reject) ctl <= ctl_nx;
      err <= (err & ~st_clr) | {rd_err, wr_err, short_p, nolat, reject};
      if (latch_ok) begin
        lat_v <= 1'b1;
        lat_a <= wr_idx;
        lat_d <= req_wdata;
      end else if (commit) begin
        lat_v <= 1'b0;
      end
      if (pgm_on) cnt <= CW'(1);
      else if (ctl[0] && cnt < CW'(MIN_PULSE)) cnt <= cnt + CW'(1);
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rdata;
    end
  end
endmodule

// File: rtl/eeprom_seq_ctrl_chk.sv
module eeprom_seq_ctrl_chk #(
  parameter int MIN_PULSE = 10000,
  parameter int CW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [1:0]    req_space,
  input logic          rsp_valid,
  input logic [4:0]    ctl,
  input logic [4:0]    err,
  input logic          lat_v,
  input logic [CW-1:0] cnt
);
  assert_no_double_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl[1:0]) == 2'b00) |-> (ctl[1:0] != 2'b11));

  assert_pgm_under_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[0] |-> ctl[1]);

  assert_latch_drop_on_commit_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lat_v) |-> ($past(ctl[0]) && !ctl[0]));

  assert_sticky_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(err) & ~err) != 5'd0) |-> $past(req_valid && req_write && req_space == 2'd2));

  assert_counter_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(MIN_PULSE));

  assert_read_response_R14: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
endmodule

bind eeprom_seq_ctrl eeprom_seq_ctrl_chk #(.MIN_PULSE(MIN_PULSE), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_space(req_space), .rsp_valid(rsp_valid), .ctl(ctl), .err(err),
  .lat_v(lat_v), .cnt(cnt)
);

// File: tb/eeprom_seq_ctrl_bench.sv
module eeprom_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ARR = 512;
  localparam int MINP = 100;
  localparam int AW = $clog2(ARR + 1);
  localparam logic [1:0] S_ARR = 2'd0, S_CTL = 2'd1, S_ST = 2'd2, S_CFG = 2'd3;
  localparam logic [7:0] PGM = 8'h01, LAT = 8'h02, ERA = 8'h04, ROW = 8'h08, BYT = 8'h10;

  localparam logic [23:0] TBL [8] = '{
    24'hFF_00_01, 24'h1E_1E_00, 24'hE0_00_00, 24'h02_02_00,
    24'h03_03_02, 24'h02_02_04, 24'h01_00_00, 24'h00_00_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_space = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  int total = 0, bad = 0;
  logic [7:0] q;
  logic last_rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_seq_ctrl #(.ARRAY_BYTES(ARR), .ROW_BYTES(16), .MIN_PULSE(MINP)) u_eeprom_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] sp, input logic w, input int a, input logic [7:0] d);
    req_valid = 1'b1; req_write = w; req_space = sp; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    q = rsp_rdata; last_rv = rsp_valid;
  endtask

  task automatic wr(input logic [1:0] sp, input int a, input logic [7:0] d);
    acc(sp, 1'b1, a, d);
  endtask

  task automatic rd(input logic [1:0] sp, input int a);
    acc(sp, 1'b0, a, 8'h00);
  endtask

  task automatic oper(input logic [1:0] sp, input int a, input logic [7:0] d,
                      input logic [7:0] mode, input int len);
    wr(S_CTL, 0, mode | LAT);
    wr(sp, a, d);
    wr(S_CTL, 0, mode | LAT | PGM);
    repeat (len - 1) @(negedge clk);
    wr(S_CTL, 0, mode | LAT);
    wr(S_CTL, 0, 8'h00);
  endtask

  task automatic warm_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R14 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;

    // reset state R12
    rd(S_CTL, 0); chk("R12 ctl after reset", q, 8'h00);
    chk("R14 read response valid", {7'd0, last_rv}, 8'h01);
    chk("R14 ready high", {7'd0, req_ready}, 8'h01);
    rd(S_ST, 0);  chk("R12 status after reset", q, 8'h00);
    rd(S_CFG, 0); chk("R12 live config erased", q, 8'hFF);
    rd(S_ARR, 0); chk("R12 array erased", q, 8'hFF);
    wr(S_ST, 0, 8'h00);
    chk("R14 no response for write", {7'd0, last_rv}, 8'h00);

    // control register table R1 R2 R3 R5
    for (int i = 0; i < 8; i++) begin
      wr(S_CTL, 0, TBL[i][23:16]);
      rd(S_CTL, 0); chk("R1 ctl readback", q, TBL[i][15:8]);
      rd(S_ST, 0);  chk("R2/R3/R5 status after ctl write", q, TBL[i][7:0]);
      wr(S_ST, 0, 8'h1F);
    end

    // program R6 with exact minimum pulse R5
    oper(S_ARR, 5, 8'hA5, 8'h00, MINP);
    rd(S_ARR, 5); chk("R6 first program", q, 8'hA5);
    oper(S_ARR, 5, 8'h0F, 8'h00, MINP);
    rd(S_ARR, 5); chk("R6 AND program", q, 8'h05);
    rd(S_ST, 0);  chk("R5 exact pulse no flag", q, 8'h00);

    // latch, interlock, short pulse R4 R11 R5 R13
    wr(S_CTL, 0, LAT);
    wr(S_ARR, 7, 8'h00);
    rd(S_ST, 0);  chk("R4 latch valid", q, 8'h20);
    rd(S_ARR, 7); chk("R4 storage untouched by latch", q, 8'hFF);
    rd(S_ST, 0);  chk("R11 read during latch", q, 8'h30);
    wr(S_ARR, 7, 8'h0F);
    rd(S_ST, 0);  chk("R4 second write flagged", q, 8'h38);
    wr(S_CTL, 0, LAT | PGM);
    repeat (MINP - 2) @(negedge clk);
    wr(S_CTL, 0, LAT);
    rd(S_ST, 0);  chk("R5 short pulse flagged R13 latch cleared", q, 8'h1C);
    wr(S_CTL, 0, 8'h00);
    rd(S_ARR, 7); chk("R5 short pulse still commits", q, 8'h00);
    wr(S_ST, 0, 8'h04);
    rd(S_ST, 0);  chk("R13 partial clear", q, 8'h18);
    wr(S_ST, 0, 8'h1F);
    rd(S_ST, 0);  chk("R13 full clear", q, 8'h00);
    wr(S_ARR, 9, 8'h00);
    rd(S_ST, 0);  chk("R4 write without latch mode", q, 8'h08);
    rd(S_ARR, 9); chk("R4 write without latch mode ignored", q, 8'hFF);
    wr(S_ST, 0, 8'h1F);

    // row erase R8, byte priority R7
    oper(S_ARR, 15, 8'h00, 8'h00, MINP);
    oper(S_ARR, 16, 8'h00, 8'h00, MINP);
    oper(S_ARR, 31, 8'h00, 8'h00, MINP);
    oper(S_ARR, 32, 8'h00, 8'h00, MINP);
    oper(S_ARR, 33, 8'h00, 8'h00, MINP);
    oper(S_ARR, 20, 8'h00, ERA | ROW, MINP);
    rd(S_ARR, 15); chk("R8 byte below row kept", q, 8'h00);
    rd(S_ARR, 16); chk("R8 row start erased", q, 8'hFF);
    rd(S_ARR, 31); chk("R8 row end erased", q, 8'hFF);
    rd(S_ARR, 32); chk("R8 byte above row kept", q, 8'h00);
    oper(S_ARR, 32, 8'h00, ERA | ROW | BYT, MINP);
    rd(S_ARR, 32); chk("R7 byte erased", q, 8'hFF);
    rd(S_ARR, 33); chk("R7 BYT over ROW neighbour kept", q, 8'h00);

    // config byte and enable R12 R10
    oper(S_CFG, 0, 8'hFE, 8'h00, MINP);
    rd(S_CFG, 0); chk("R12 live config waits for reset", q, 8'hFF);
    warm_reset();
    rd(S_CFG, 0); chk("R12 live config reloaded", q, 8'hFE);
    rd(S_ARR, 5); chk("R12 disabled array reads zero", q, 8'h00);
    wr(S_CTL, 0, LAT);
    wr(S_ARR, 0, 8'h00);
    rd(S_ST, 0);  chk("R12 disabled array write ignored", q, 8'h00);
    wr(S_CTL, 0, 8'h00);
    oper(S_CFG, 0, 8'h55, ERA, MINP);
    warm_reset();
    rd(S_CFG, 0); chk("R10 config erased", q, 8'hFF);
    rd(S_ARR, 5); chk("R10 bulk mode on config spares array", q, 8'h05);
    rd(S_ARR, 33); chk("R10 array byte kept", q, 8'h00);
    rd(S_ARR, 0); chk("R12 disabled write left byte", q, 8'hFF);

    // bulk erase R9
    oper(S_CFG, 0, 8'h7F, 8'h00, MINP);
    warm_reset();
    rd(S_CFG, 0); chk("R9 config before bulk", q, 8'h7F);
    oper(S_ARR, 40, 8'h00, ERA, MINP);
    warm_reset();
    rd(S_CFG, 0); chk("R9 bulk erases config", q, 8'hFF);
    rd(S_ARR, 5); chk("R9 bulk erases byte 5", q, 8'hFF);
    rd(S_ARR, 7); chk("R9 bulk erases byte 7", q, 8'hFF);
    rd(S_ARR, 33); chk("R9 bulk erases byte 33", q, 8'hFF);

    // reset mid-latch R12
    wr(S_CTL, 0, LAT);
    wr(S_ARR, 1, 8'h00);
    rd(S_ST, 0);  chk("R4 latch before reset", q, 8'h20);
    warm_reset();
    rd(S_CTL, 0); chk("R12 ctl cleared", q, 8'h00);
    rd(S_ST, 0);  chk("R12 latch cleared", q, 8'h00);
    rd(S_ARR, 1); chk("R12 latched byte not stored", q, 8'hFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule